// File: doc/BRIEF.md
# Serial Register Control Port

This block is a serial control port that lets an external host configure a chip through four pins: an active-low chip select, a serial clock, serial data in and serial data out. The host shifts in a 24-bit control word, most significant bit first. The word's top bit selects write (0) or read (1), the next seven bits give a register address, and the low sixteen bits carry data. The word is acted on only when chip select rises. A write updates a bank of 16-bit configuration registers. A read returns a register over the serial output during the data phase of the same frame.

All three input pins are sampled by the system clock through two-flop synchronizers, and edges are detected in that domain. The serial clock may run at up to one quarter of the system clock. A frame controller has four states. `ST_IDLE` waits for chip select to fall and then moves to `ST_HEAD`. `ST_HEAD` collects the eight header bits and moves to `ST_BODY` on the eighth rising serial clock edge, or to `ST_COMMIT` if chip select rises first. `ST_BODY` keeps shifting, and in a read frame it drives read data out. It moves to `ST_COMMIT` when chip select rises. `ST_COMMIT` lasts one cycle, applies any write, and returns to `ST_IDLE`.

Two addresses hold read-only identity values: a device identifier and a revision number. A write to address zero restores the whole bank to its default values. Addresses 06h and 07h cannot be reached from this port. The register contents are presented in parallel to the rest of the chip, and a one-cycle strobe reports each accepted write.

Top module: `spi_ctrl_slave`

## Requirements
- R1: After reset, every writable register (addresses 2 to NUM_REGS-1 except 6 and 7) holds its default value {1'b0, addr[6:0], 8'h00}. Slots 0, 1, 6 and 7 of `regs_out` read zero, and `wr_stb` and `spi_sdo_oe` are low.
- R2: A frame of exactly 24 bits with bit 23 = 0 writes bits 15:0 into the register addressed by bits 22:16. The new value appears in `regs_out` slot `addr` (bits addr*16 +: 16) after chip select rises.
- R3: Each write accepted into a writable register raises `wr_stb` for exactly one system clock cycle. In that cycle `wr_addr` and `wr_data` carry the address and data.
- R4: When more than 24 bits are shifted while chip select is low, only the last 24 bits form the committed word, provided the first bit of the frame was 0.
- R5: A frame of fewer than 24 bits changes no register and produces no strobe. `regs_out` changes only in the cycle after a commit.
- R6: A write of any data to address 00h restores every writable register to its default and raises no strobe.
- R7: In a read frame (first bit 1), the addressed register's 16 bits appear on `spi_sdo`, MSB first. Each bit is updated after a falling serial clock edge, starting with the fall that follows the eighth rising edge, so the host samples bits 15..0 on rising edges 9..24. The data-phase bits on `spi_sdi` are ignored and cause no write.
- R8: A read of address 00h returns the DEVICE_ID parameter.
- R9: A read of address 01h returns the REVISION parameter in bits 2:0 with bits 15:3 zero.
- R10: Writes to addresses 06h and 07h are ignored (no strobe, `regs_out` unchanged), and reads of them return zero.
- R11: Addresses at or above NUM_REGS read zero and ignore writes without a strobe.
- R12: `spi_sdo_oe` is high only in the data phase of a read frame, and it is low whenever the synchronized chip select has been high for more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low; its rising edge commits a frame |
| spi_sck | input | 1 | Serial clock from the host |
| spi_sdi | input | 1 | Serial data from the host, sampled on rising serial clock edges |
| spi_sdo | output | 1 | Serial read data |
| spi_sdo_oe | output | 1 | Output enable for `spi_sdo` |
| regs_out | output | NUM_REGS*16 | All register slots in parallel, slot n at bits n*16 +: 16 |
| wr_stb | output | 1 | One-cycle pulse per accepted write |
| wr_addr | output | 7 | Address of the accepted write |
| wr_data | output | 16 | Data of the accepted write |

## Verification
The bench aims at the points where frame framing goes wrong. A frame padded with extra leading bits would write the wrong address if the design latched its word from the first 24 bits rather than the last. A 20-bit frame would corrupt a register if the design committed without checking the bit count. Read frames carry all-ones data bits, so a design that let those bits through would overwrite the register being read. Reads of the identity, reserved and unmapped addresses catch a missing decode, and a write to address zero that issues a strobe, or leaves a register unrestored, shows a faulty bank reset.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;

    localparam int CTRL_ADDR_W = 7;
    localparam int CTRL_DATA_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEAD,
        ST_BODY,
        ST_COMMIT
    } frame_state_t;

    // default contents of a writable slot
    function automatic logic [CTRL_DATA_W-1:0] reg_default(input logic [CTRL_ADDR_W-1:0] a);
        return {1'b0, a, 8'h00};
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] ff;
        logic              prev;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ff   <= {STAGES{RST_VAL[g]}};
                prev <= RST_VAL[g];
            end else begin
                ff   <= {ff[STAGES-2:0], d_in[g]};
                prev <= ff[STAGES-1];
            end
        end

        assign lvl[g]  = ff[STAGES-1];
        assign rise[g] = ff[STAGES-1] & ~prev;
        assign fall[g] = ~ff[STAGES-1] & prev;
    end

endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_ctrl_pkg::*;
#(
    parameter int ADDR_W = CTRL_ADDR_W,
    parameter int DATA_W = CTRL_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sdi_lvl,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              commit_we,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data,
    output logic              sdo,
    output logic              sdo_oe
);

    localparam int FRAME_W = 1 + ADDR_W + DATA_W;
    localparam int HEAD_W  = 1 + ADDR_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    frame_state_t         state, nxt;
    logic [FRAME_W-1:0]   sreg;
    logic [CNT_W-1:0]     cnt;
    logic                 rd_frame;
    logic                 load_pend;
    logic [DATA_W-1:0]    out_sr;
    logic                 sdo_q;
    logic [HEAD_W-1:0]    hdr;
    logic                 head_done;

    assign hdr       = {sreg[HEAD_W-2:0], sdi_lvl};
    assign head_done = sck_rise && (cnt == CNT_W'(HEAD_W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (cs_fall) nxt = ST_HEAD;
            ST_HEAD:   if (cs_rise) nxt = ST_COMMIT;
                       else if (head_done) nxt = ST_BODY;
            ST_BODY:   if (cs_rise) nxt = ST_COMMIT;
            ST_COMMIT: nxt = ST_IDLE;
        endcase
    end

    // shift, count and read-out datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg      <= '0;
            cnt       <= '0;
            rd_frame  <= 1'b0;
            rd_addr   <= '0;
            load_pend <= 1'b0;
            out_sr    <= '0;
            sdo_q     <= 1'b0;
        end else begin
            if (state == ST_IDLE) begin
                sdo_q <= 1'b0;
                if (cs_fall) begin
                    cnt      <= '0;
                    rd_frame <= 1'b0;
                end
            end
            if ((state == ST_HEAD || state == ST_BODY) && sck_rise) begin
                sreg <= {sreg[FRAME_W-2:0], sdi_lvl};
                if (cnt != CNT_W'(FRAME_W)) cnt <= cnt + 1'b1;
            end
            if (state == ST_HEAD && head_done && !cs_rise) begin
                rd_frame  <= hdr[HEAD_W-1];
                rd_addr   <= hdr[ADDR_W-1:0];
                load_pend <= hdr[HEAD_W-1];
            end
            if (load_pend) begin
                out_sr    <= rd_data;
                load_pend <= 1'b0;
            end else if (state == ST_BODY && rd_frame && sck_fall) begin
                sdo_q  <= out_sr[DATA_W-1];
                out_sr <= {out_sr[DATA_W-2:0], 1'b0};
            end
            if (state == ST_COMMIT) sdo_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        commit_we   = (state == ST_COMMIT) && (cnt == CNT_W'(FRAME_W))
                      && !rd_frame && !sreg[FRAME_W-1];
        commit_addr = sreg[FRAME_W-2 -: ADDR_W];
        commit_data = sreg[DATA_W-1:0];
        sdo_oe      = (state == ST_BODY) && rd_frame;
        sdo         = sdo_q && sdo_oe;
    end

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_ctrl_pkg::*;
#(
    parameter int          NUM_REGS  = 16,
    parameter int          ADDR_W    = CTRL_ADDR_W,
    parameter int          DATA_W    = CTRL_DATA_W,
    parameter logic [DATA_W-1:0] DEVICE_ID = 16'h5A31,
    parameter logic [2:0]  REVISION  = 3'd2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          waddr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [ADDR_W-1:0]          raddr,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat,
    output logic                       wr_stb,
    output logic [ADDR_W-1:0]          wr_addr,
    output logic [DATA_W-1:0]          wr_data
);

    localparam int IDX_W = $clog2(NUM_REGS);

    function automatic logic writable(input logic [ADDR_W-1:0] a);
        return (a >= ADDR_W'(2)) && (a < ADDR_W'(NUM_REGS))
               && (a != ADDR_W'(6)) && (a != ADDR_W'(7));
    endfunction

    logic [DATA_W-1:0] slot_q [NUM_REGS];
    logic              bank_clear;

    assign bank_clear = we && (waddr == '0);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        if (g >= 2 && g != 6 && g != 7) begin : g_rw
            localparam logic [DATA_W-1:0] DEF = DATA_W'(reg_default(ADDR_W'(g)));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                slot_q[g] <= DEF;
                else if (bank_clear)                       slot_q[g] <= DEF;
                else if (we && waddr == ADDR_W'(g))        slot_q[g] <= wdata;
            end
        end else begin : g_fixed
            assign slot_q[g] = '0;
        end
        assign regs_flat[g*DATA_W +: DATA_W] = slot_q[g];
    end

    always_comb begin
        if (raddr == ADDR_W'(0))             rdata = DEVICE_ID;
        else if (raddr == ADDR_W'(1))        rdata = DATA_W'(REVISION);
        else if (raddr < ADDR_W'(NUM_REGS))  rdata = slot_q[raddr[IDX_W-1:0]];
        else                                 rdata = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= we && writable(waddr);
            if (we && writable(waddr)) begin
                wr_addr <= waddr;
                wr_data <= wdata;
            end
        end
    end

endmodule

// File: rtl/spi_ctrl_slave.sv
module spi_ctrl_slave
    import spi_ctrl_pkg::*;
#(
    parameter int          NUM_REGS    = 16,
    parameter logic [15:0] DEVICE_ID   = 16'h5A31,
    parameter logic [2:0]  REVISION    = 3'd2,
    parameter int          SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   spi_cs_n,
    input  logic                   spi_sck,
    input  logic                   spi_sdi,
    output logic                   spi_sdo,
    output logic                   spi_sdo_oe,
    output logic [NUM_REGS*16-1:0] regs_out,
    output logic                   wr_stb,
    output logic [6:0]             wr_addr,
    output logic [15:0]            wr_data
);

    logic [2:0]  pin_lvl, pin_rise, pin_fall;
    logic        cs_lvl;
    logic [6:0]  rd_addr, commit_addr;
    logic [15:0] rd_data, commit_data;
    logic        commit_we;

    // bit 2: chip select (idles high), bit 1: serial clock, bit 0: data
    spi_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in ({spi_cs_n, spi_sck, spi_sdi}),
        .lvl  (pin_lvl),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    assign cs_lvl = pin_lvl[2];

    spi_frame_fsm #(
        .ADDR_W(CTRL_ADDR_W),
        .DATA_W(CTRL_DATA_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_fall    (pin_fall[2]),
        .cs_rise    (pin_rise[2]),
        .sck_rise   (pin_rise[1]),
        .sck_fall   (pin_fall[1]),
        .sdi_lvl    (pin_lvl[0]),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .commit_we  (commit_we),
        .commit_addr(commit_addr),
        .commit_data(commit_data),
        .sdo        (spi_sdo),
        .sdo_oe     (spi_sdo_oe)
    );

    spi_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (CTRL_ADDR_W),
        .DATA_W   (CTRL_DATA_W),
        .DEVICE_ID(DEVICE_ID),
        .REVISION (REVISION)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (commit_we),
        .waddr    (commit_addr),
        .wdata    (commit_data),
        .raddr    (rd_addr),
        .rdata    (rd_data),
        .regs_flat(regs_out),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

endmodule

// File: rtl/spi_ctrl_slave_chk.sv
module spi_ctrl_slave_chk #(
    parameter int NUM_REGS = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cs_lvl,
    input logic                   commit_we,
    input logic                   spi_sdo_oe,
    input logic [NUM_REGS*16-1:0] regs_out,
    input logic                   wr_stb,
    input logic [6:0]             wr_addr,
    input logic [15:0]            wr_data
);

    logic cs_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_lvl;
    end

    function automatic logic [15:0] slot_of(input logic [NUM_REGS*16-1:0] v,
                                            input logic [6:0] a);
        logic [15:0] r;
        r = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (a == 7'(i)) r = v[i*16 +: 16];
        return r;
    endfunction

    // R3
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R10
    stb_addr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_addr >= 7'd2 && wr_addr < 7'(NUM_REGS)
                    && wr_addr != 7'd6 && wr_addr != 7'd7));

    // R2
    stb_data_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (slot_of(regs_out, wr_addr) == wr_data));

    // R5
    regs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(commit_we) |-> $stable(regs_out));

    // R12
    oe_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_lvl && cs_q) |-> !spi_sdo_oe);

endmodule

bind spi_ctrl_slave spi_ctrl_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_lvl    (cs_lvl),
    .commit_we (commit_we),
    .spi_sdo_oe(spi_sdo_oe),
    .regs_out  (regs_out),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
);

// File: tb/spi_ctrl_slave_test.sv
module spi_ctrl_slave_test;

    localparam int          NR  = 16;
    localparam logic [15:0] DID = 16'h5A31;
    localparam logic [2:0]  REV = 3'd2;
    localparam int          HP  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_sck = 1'b0;
    logic spi_sdi = 1'b0;
    logic spi_sdo, spi_sdo_oe, wr_stb;
    logic [NR*16-1:0] regs_out;
    logic [6:0]  wr_addr;
    logic [15:0] wr_data;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [22:0] stb_q [$];
    logic [15:0] rd_q  [$];
    string       rd_tag [$];

    always #4 clk = ~clk;

    spi_ctrl_slave #(.NUM_REGS(NR), .DEVICE_ID(DID), .REVISION(REV)) uut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
        .regs_out(regs_out), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [15:0] dflt(input int a);
        if (a < 2 || a == 6 || a == 7 || a >= NR) return 16'h0;
        return {1'b0, 7'(a), 8'h00};
    endfunction

    function automatic logic [15:0] slot(input int a);
        return regs_out[a*16 +: 16];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [31:0] bits, input int n);
        spi_cs_n = 1'b0;
        wait_clk(HP);
        for (int i = n - 1; i >= 0; i--) begin
            spi_sdi = bits[i];
            wait_clk(HP);
            spi_sck = 1'b1;
            wait_clk(HP);
            spi_sck = 1'b0;
        end
        wait_clk(HP);
        spi_cs_n = 1'b1;
        wait_clk(12);
    endtask

    // writable targets push an expected strobe
    task automatic do_write(input int a, input logic [15:0] d, input bit expect_stb);
        if (expect_stb) stb_q.push_back({7'(a), d});
        frame({8'h00, 1'b0, 7'(a), d}, 24);
    endtask

    task automatic do_read(input int a, input logic [15:0] exp, input string tag);
        rd_q.push_back(exp);
        rd_tag.push_back(tag);
        frame({8'h00, 1'b1, 7'(a), 16'hFFFF}, 24);
    endtask

    // strobe monitor (R3)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && wr_stb) begin
                if (stb_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected strobe", {9'h0, wr_addr, wr_data}, 32'h0);
                end else begin
                    logic [22:0] e;
                    e = stb_q.pop_front();
                    chk({wr_addr, wr_data} == e, "R3 strobe addr/data", {9'h0, wr_addr, wr_data}, {9'h0, e});
                end
            end
        end
    end

    // read monitor (R7, R12): collect bits on rising serial clock while enabled
    initial begin
        logic [15:0] sr;
        int nb;
        nb = 0;
        sr = '0;
        forever begin
            @(posedge spi_sck);
            if (spi_sdo_oe) begin
                sr = {sr[14:0], spi_sdo};
                nb++;
                if (nb == 16) begin
                    nb = 0;
                    if (rd_q.size() == 0) begin
                        chk(1'b0, "R7 unexpected read data", {16'h0, sr}, 32'h0);
                    end else begin
                        logic [15:0] e;
                        string t;
                        e = rd_q.pop_front();
                        t = rd_tag.pop_front();
                        chk(sr == e, t, {16'h0, sr}, {16'h0, e});
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);

        // R1: reset state
        begin
            bit ok;
            ok = 1'b1;
            for (int a = 0; a < NR; a++) if (slot(a) != dflt(a)) ok = 1'b0;
            chk(ok, "R1 register defaults", {16'h0, slot(3)}, {16'h0, dflt(3)});
        end
        chk(!wr_stb && !spi_sdo_oe, "R1 idle outputs", {30'h0, wr_stb, spi_sdo_oe}, 32'h0);

        // R2/R3: writes
        do_write(2, 16'hA5A5, 1);
        chk(slot(2) == 16'hA5A5, "R2 write slot 2", {16'h0, slot(2)}, 32'hA5A5);
        do_write(5, 16'h1234, 1);
        do_write(NR - 1, 16'hBEEF, 1);
        chk(slot(5) == 16'h1234, "R2 write slot 5", {16'h0, slot(5)}, 32'h1234);
        chk(slot(NR-1) == 16'hBEEF, "R2 write top slot", {16'h0, slot(NR-1)}, 32'hBEEF);
        chk(spi_sdo_oe == 1'b0, "R12 oe low with cs high", {31'h0, spi_sdo_oe}, 32'h0);

        // R7: read back; data bits are all ones and must not write
        do_read(2, 16'hA5A5, "R7 read slot 2");
        chk(slot(2) == 16'hA5A5, "R7 read leaves register", {16'h0, slot(2)}, 32'hA5A5);
        do_read(NR - 1, 16'hBEEF, "R7 read top slot");
        do_read(3, dflt(3), "R7 read default slot 3");

        // R8/R9: identity
        do_read(0, DID, "R8 device id");
        do_read(1, {13'h0, REV}, "R9 revision");

        // R10: reserved addresses
        do_write(6, 16'h5555, 0);
        do_write(7, 16'hAAAA, 0);
        chk(slot(6) == 16'h0 && slot(7) == 16'h0, "R10 reserved slots", {slot(6), slot(7)}, 32'h0);
        do_read(6, 16'h0, "R10 read addr 6");
        do_read(7, 16'h0, "R10 read addr 7");

        // R11: unmapped address
        do_write(7'h20, 16'h7777, 0);
        do_read(7'h20, 16'h0, "R11 read unmapped");

        // R4: 8 junk bits ahead of a valid word
        stb_q.push_back({7'd3, 16'h7E81});
        frame({8'h3C, 1'b0, 7'd3, 16'h7E81}, 32);
        chk(slot(3) == 16'h7E81, "R4 last 24 bits", {16'h0, slot(3)}, 32'h7E81);

        // R5: short frame (20 bits) commits nothing
        frame({12'h0, 1'b0, 7'd4, 12'hF0F}, 20);
        chk(slot(4) == dflt(4), "R5 short frame ignored", {16'h0, slot(4)}, {16'h0, dflt(4)});

        // R6: write to address zero restores defaults, no strobe
        do_write(0, 16'hFFFF, 0);
        begin
            bit ok;
            ok = 1'b1;
            for (int a = 0; a < NR; a++) if (slot(a) != dflt(a)) ok = 1'b0;
            chk(ok, "R6 bank restored", {16'h0, slot(2)}, {16'h0, dflt(2)});
        end
        do_read(5, dflt(5), "R6 read restored slot 5");

        wait_clk(20);
        chk(stb_q.size() == 0, "R3 all strobes seen", stb_q.size(), 32'h0);
        chk(rd_q.size() == 0, "R7 all reads seen", rd_q.size(), 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule